// File: doc/BRIEF.md
# Command-Sequenced SPI Master

This block is a single-lane SPI master. A queue of 20-bit command words drives everything it does on the serial pins. Two 32-bit data queues sit next to it, one for transmit and one for receive. Each command word does one of three jobs: it holds chip select at a chosen level for a number of SCLK periods, it shifts out a single byte carried inside the command, or it moves a counted run of bytes through the data queues.

A counted run can give its length either as a plain count or as a power of two. Software builds a whole transaction ahead of time by queueing commands: the chip-select setup, the opcode, an address, a data burst and the chip-select release. The engine then runs the queue on its own. Clock polarity, clock phase and a 3-bit divider are static inputs. Three status flags show the state of the queues. An enable input freezes or releases the whole engine.

Top module: `cqspi_master`

## Requirements
- R1: After reset, cs_n is 1, mosi is 1, sclk sits at cfg_cpol, cmd_empty is 1, tx_not_full is 1 and rx_not_empty is 0.
- R2: While en is 0, no command is taken from the queue, and cs_n and sclk do not change.
- R3: A command with bits 8, 16 and 17 all clear is a hold command. It drives cs_n to the inverse of bit 12 on the next clock. It then waits imm = bits [7:0] SCLK periods before the next command is taken, which is imm·2^(cfg_div+1) clock cycles; imm of 0 waits nothing. With the next command already queued, cs_n therefore stays at its new level for imm·2^(cfg_div+1)+1 cycles.
- R4: A command with bit 8 clear and bit 16 set shifts the byte in bits [7:0] out on mosi, most significant bit first.
- R5: A command with bit 8 set and bit 9 clear moves bits [7:0] bytes, counted from 1 to 255. With bit 16 set, the bytes come from the transmit queue, least significant byte of each word first. Unused bytes of the last word are dropped and never shifted, so the next burst starts on a fresh word.
- R6: A command with bits 8 and 9 both set moves 2^n bytes, where n is bits [3:0].
- R7: Each SCLK half period lasts 2^cfg_div clock cycles, so the 16 edges of one byte span 15·2^cfg_div cycles.
- R8: SCLK idles at cfg_cpol and makes exactly 16 edges per byte. When cfg_cpha is 0, mosi is valid before the leading edge and miso is sampled on it. When cfg_cpha is 1, mosi changes on the leading edge and miso is sampled on the trailing edge.
- R9: With bit 17 set, each received byte is packed into a 32-bit word, least significant byte first. A full word is pushed to the receive queue, and so is a partial word at the end of the run, with its unused bytes zero. A run without bit 16 drives mosi to 1 for every bit.
- R10: If the transmit queue is empty when a burst needs its next word, the engine waits with SCLK idle and makes no edge until a word arrives. It never shifts a byte that was not supplied.
- R11: cmd_empty shows that the command queue is empty, tx_not_full that the transmit queue has room, and rx_not_empty that a received word is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Engine enable; 0 freezes all activity |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | Selects the sampling edge |
| cfg_div | input | 3 | SCLK half period is 2^cfg_div clocks |
| cmd_push | input | 1 | Writes cmd_word into the command queue |
| cmd_word | input | 20 | Command word |
| tx_push | input | 1 | Writes tx_word into the transmit queue |
| tx_word | input | 32 | Transmit data word |
| rx_pop | input | 1 | Removes the head of the receive queue |
| rx_data | output | 32 | Head of the receive queue |
| cmd_empty | output | 1 | Command queue is empty |
| tx_not_full | output | 1 | Transmit queue has room |
| rx_not_empty | output | 1 | Receive queue holds a word |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong shift or half-period count shows up within one byte. The slave model then stores a byte with shifted bits, the edge count differs from 16, or the edge spacing differs from 15·2^cfg_div cycles. A wrong byte index in the transmit or receive packer shows only at a word or burst boundary, as a repeated or skipped byte or as a stale upper byte in a partial word. The tests therefore cross those boundaries on purpose. A wrong hold counter shows as a chip-select low time that is off by whole SCLK periods. The stall test shows any edge made while no data is available.

// File: rtl/cqspi_pkg.sv
// Package: command word field positions and the engine state type.
// Assumes a 20-bit command word with single-lane operation only.
package cqspi_pkg;
    localparam int CMD_W  = 20;
    localparam int B_XFER = 8;   // counted run through the data queues
    localparam int B_EXP  = 9;   // run length is a power of two
    localparam int B_CS   = 12;  // chip-select level for hold commands
    localparam int B_TX   = 16;  // transmit from queue
    localparam int B_RX   = 17;  // receive into queue

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_LOAD,
        ST_SHIFT
    } eng_state_t;
endpackage

// File: rtl/cqspi_fifo.sv
// Module: synchronous first-word-fall-through queue.
// Assumes DEPTH is a power of two. A push when full or a pop when empty is ignored.
module cqspi_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign rdata   = mem[rp_q];

    // Storage write; needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= wdata;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/cqspi_engine.sv
// Module: command decoder, clock divider, chip-select control and byte shifter.
// Assumes queue heads are valid in the same cycle that their empty flag is low.
// Within a byte, miso is sampled on every even-to-odd half step and mosi
// advances on odd-to-even steps; cfg_cpha only moves where SCLK toggles.
module cqspi_engine
    import cqspi_pkg::*;
#(
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [2:0]       div,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             cmd_empty,
    output logic             cmd_pop,
    input  logic [DW-1:0]    tx_word,
    input  logic             tx_empty,
    output logic             tx_pop,
    input  logic             rx_full,
    output logic             rx_push,
    output logic [DW-1:0]    rx_word,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n,
    output logic             shifting
);
    localparam int NB   = DW / 8;
    localparam int BI_W = $clog2(NB);

    eng_state_t       state_q;
    logic             cs_n_q, half_q, do_tx_q, do_rx_q, from_imm_q, tvalid_q;
    logic [7:0]       dcnt_q, hcnt_q, imm_q, sh_q, rxsh_q;
    logic [3:0]       h_q;
    logic [CNT_W-1:0] left_q, cmd_len;
    logic [DW-1:0]    txw_q, rxw_q;
    logic [BI_W-1:0]  tbi_q, rbi_q;
    logic [7:0]       lim, load_byte;
    logic             tick, is_hold, need_word, load_ok, byte_end;

    // Decode of the queue head and per-cycle strobes.
    always_comb begin
        lim       = (8'd1 << div) - 8'd1;
        tick      = (dcnt_q == lim);
        is_hold   = !cmd_word[B_XFER] && !cmd_word[B_TX] && !cmd_word[B_RX];
        cmd_len   = cmd_word[B_EXP] ? (CNT_W'(1) << cmd_word[3:0])
                                    : CNT_W'(cmd_word[7:0]);
        need_word = do_tx_q && !from_imm_q && !tvalid_q;
        load_ok   = !((need_word && tx_empty) || (do_rx_q && rx_full));
        cmd_pop   = en && (state_q == ST_IDLE) && !cmd_empty;
        tx_pop    = en && (state_q == ST_LOAD) && load_ok && need_word;
        byte_end  = (state_q == ST_SHIFT) && tick && (h_q == 4'hF);
        rx_push   = en && byte_end && do_rx_q &&
                    ((rbi_q == BI_W'(NB-1)) || (left_q == CNT_W'(1)));
    end

    // Selection of the next outgoing byte.
    always_comb begin
        if (from_imm_q)     load_byte = imm_q;
        else if (!do_tx_q)  load_byte = 8'hFF;
        else if (need_word) load_byte = tx_word[7:0];
        else                load_byte = txw_q[tbi_q*8 +: 8];
    end

    // Receive word with the finished byte merged at its lane.
    always_comb begin
        rx_word = rxw_q;
        rx_word[rbi_q*8 +: 8] = rxsh_q;
    end

    assign shifting = (state_q == ST_SHIFT);
    assign sclk     = shifting ? (cpol ^ (cpha ? ~h_q[0] : h_q[0])) : cpol;
    assign mosi     = shifting ? sh_q[7] : 1'b1;
    assign cs_n     = cs_n_q;

    // Sequencer: fetch, hold, byte load and bit shifting; frozen while en is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cs_n_q     <= 1'b1;
            half_q     <= 1'b0;
            do_tx_q    <= 1'b0;
            do_rx_q    <= 1'b0;
            from_imm_q <= 1'b0;
            tvalid_q   <= 1'b0;
            dcnt_q     <= '0;
            hcnt_q     <= '0;
            imm_q      <= '0;
            sh_q       <= '1;
            rxsh_q     <= '0;
            h_q        <= '0;
            left_q     <= '0;
            txw_q      <= '0;
            rxw_q      <= '0;
            tbi_q      <= '0;
            rbi_q      <= '0;
        end else if (en) begin
            unique case (state_q)
                ST_IDLE: if (!cmd_empty) begin
                    dcnt_q <= '0;
                    half_q <= 1'b0;
                    imm_q  <= cmd_word[7:0];
                    if (is_hold) begin
                        cs_n_q  <= ~cmd_word[B_CS];
                        hcnt_q  <= cmd_word[7:0];
                        state_q <= (cmd_word[7:0] != 8'd0) ? ST_HOLD : ST_IDLE;
                    end else begin
                        do_tx_q    <= cmd_word[B_TX];
                        do_rx_q    <= cmd_word[B_RX];
                        rxw_q      <= '0;
                        rbi_q      <= '0;
                        from_imm_q <= !cmd_word[B_XFER];
                        if (!cmd_word[B_XFER]) begin
                            left_q  <= CNT_W'(1);
                            state_q <= ST_LOAD;
                        end else begin
                            left_q   <= cmd_len;
                            tvalid_q <= 1'b0;
                            state_q  <= (cmd_len != '0) ? ST_LOAD : ST_IDLE;
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        dcnt_q <= '0;
                        half_q <= ~half_q;
                        if (half_q) begin
                            hcnt_q <= hcnt_q - 8'd1;
                            if (hcnt_q == 8'd1) state_q <= ST_IDLE;
                        end
                    end else begin
                        dcnt_q <= dcnt_q + 8'd1;
                    end
                end
                ST_LOAD: if (load_ok) begin
                    sh_q    <= load_byte;
                    h_q     <= '0;
                    dcnt_q  <= '0;
                    state_q <= ST_SHIFT;
                    if (do_tx_q && !from_imm_q) begin
                        if (need_word) begin
                            txw_q    <= tx_word;
                            tbi_q    <= BI_W'(1);
                            tvalid_q <= 1'b1;
                        end else begin
                            tbi_q    <= tbi_q + 1'b1;
                            tvalid_q <= (tbi_q != BI_W'(NB-1));
                        end
                    end
                end
                ST_SHIFT: begin
                    if (!tick) begin
                        dcnt_q <= dcnt_q + 8'd1;
                    end else begin
                        dcnt_q <= '0;
                        h_q    <= h_q + 4'd1;
                        if (!h_q[0]) begin
                            rxsh_q <= {rxsh_q[6:0], miso};
                        end else if (h_q != 4'hF) begin
                            sh_q <= {sh_q[6:0], 1'b1};
                        end else begin
                            if (do_rx_q) begin
                                if (rx_push) begin
                                    rxw_q <= '0;
                                    rbi_q <= '0;
                                end else begin
                                    rxw_q <= rx_word;
                                    rbi_q <= rbi_q + 1'b1;
                                end
                            end
                            left_q  <= left_q - CNT_W'(1);
                            state_q <= (left_q == CNT_W'(1)) ? ST_IDLE : ST_LOAD;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cqspi_master.sv
// Module: top level joining the command, transmit and receive queues to the engine.
// Assumes the configuration inputs change only while no command is running.
module cqspi_master #(
    parameter int CMD_DEPTH = 8,
    parameter int TX_DEPTH  = 4,
    parameter int RX_DEPTH  = 4,
    parameter int DW        = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cfg_cpol,
    input  logic          cfg_cpha,
    input  logic [2:0]    cfg_div,
    input  logic          cmd_push,
    input  logic [19:0]   cmd_word,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_word,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_data,
    output logic          cmd_empty,
    output logic          tx_not_full,
    output logic          rx_not_empty,
    output logic          sclk,
    output logic          cs_n,
    output logic          mosi,
    input  logic          miso
);
    logic [19:0]   cmd_head;
    logic [DW-1:0] tx_head, rx_word;
    logic          cmd_pop, cmd_full, tx_pop, tx_empty, tx_full;
    logic          rx_push, rx_empty, rx_full, shifting;

    assign tx_not_full  = !tx_full;
    assign rx_not_empty = !rx_empty;

    cqspi_fifo #(.W(20), .DEPTH(CMD_DEPTH)) u_cmdq (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .wdata(cmd_word),
        .pop(cmd_pop), .rdata(cmd_head), .empty(cmd_empty), .full(cmd_full));

    cqspi_fifo #(.W(DW), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_word),
        .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(tx_full));

    cqspi_fifo #(.W(DW), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_data), .empty(rx_empty), .full(rx_full));

    cqspi_engine #(.DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(en), .cpol(cfg_cpol), .cpha(cfg_cpha),
        .div(cfg_div), .cmd_word(cmd_head), .cmd_empty(cmd_empty),
        .cmd_pop(cmd_pop), .tx_word(tx_head), .tx_empty(tx_empty),
        .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push),
        .rx_word(rx_word), .miso(miso), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .shifting(shifting));
endmodule

// File: rtl/cqspi_checker.sv
// Module: protocol checker bound to cqspi_master.
// Assumes rst_n is synchronous; every property is disabled during reset.
module cqspi_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic cfg_cpol,
    input logic cmd_pop,
    input logic cs_n,
    input logic sclk,
    input logic shifting,
    input logic tx_pop,
    input logic tx_empty,
    input logic rx_push,
    input logic rx_full
);
    // R2: a disabled engine takes no command.
    p_no_pop_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !cmd_pop);

    // R2: chip select is frozen after a disabled cycle.
    p_frozen_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> $stable(cs_n));

    // R3: chip select moves only after a command was taken.
    p_cs_after_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (cs_n != $past(cs_n))) |-> $past(cmd_pop));

    // R10: a transmit word is never taken from an empty queue.
    p_tx_pop_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

    // R9: received words never overflow the receive queue.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);

    // R8: outside byte shifting SCLK holds still.
    p_sclk_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !shifting && !$past(shifting) && $stable(cfg_cpol))
        |-> $stable(sclk));
endmodule

bind cqspi_master cqspi_checker u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_cpol(cfg_cpol),
    .cmd_pop(cmd_pop), .cs_n(cs_n), .sclk(sclk), .shifting(shifting),
    .tx_pop(tx_pop), .tx_empty(tx_empty), .rx_push(rx_push), .rx_full(rx_full));

// File: tb/cqspi_master_tb_top.sv
// Bench: loopback SPI slave model, a table of mode/divider/byte vectors, then
// directed tests for reset, enable, chip-select timing, packing and stalls.
`timescale 1ns/1ps
module cqspi_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [2:0]  cfg_div = 3'd0;
    logic        cmd_push = 1'b0, tx_push = 1'b0, rx_pop = 1'b0;
    logic [19:0] cmd_word = '0;
    logic [31:0] tx_word = '0;
    logic [31:0] rx_data;
    logic        cmd_empty, tx_not_full, rx_not_empty, sclk, cs_n, mosi;
    logic        miso = 1'b1;

    int total = 0, bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cqspi_master dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_div(cfg_div), .cmd_push(cmd_push),
        .cmd_word(cmd_word), .tx_push(tx_push), .tx_word(tx_word),
        .rx_pop(rx_pop), .rx_data(rx_data), .cmd_empty(cmd_empty),
        .tx_not_full(tx_not_full), .rx_not_empty(rx_not_empty),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

    // Slave model: shift register loopback, byte log and edge stamps.
    logic [7:0] ssr = 8'h3C;
    logic [7:0] smem [16];
    int sbits = 0, scount = 0, ecnt = 0, ebad = 0, t0 = 0, t15 = 0;
    logic sclk_prev = 1'b0, cs_prev = 1'b1;
    always begin
        @(negedge clk);
        #1;
        if (cs_n) begin
            if (sclk != sclk_prev && sclk != cfg_cpol) ebad = ebad + 1;
        end else if (cs_prev) begin
            ssr = 8'h3C; sbits = 0; scount = 0; ecnt = 0;
            miso = ssr[7];
        end else if (sclk != sclk_prev) begin
            if (ecnt == 0)  t0  = cyc;
            if (ecnt == 15) t15 = cyc;
            ecnt = ecnt + 1;
            if ((sclk != cfg_cpol) ^ cfg_cpha) begin
                ssr = {ssr[6:0], mosi};
                sbits = sbits + 1;
                if (sbits == 8) begin
                    if (scount < 16) smem[scount] = ssr;
                    scount = scount + 1;
                    sbits = 0;
                end
            end else begin
                miso = ssr[7];
            end
        end
        sclk_prev = sclk;
        cs_prev   = cs_n;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_cmd(input logic [19:0] w);
        @(negedge clk); cmd_push = 1'b1; cmd_word = w;
        @(negedge clk); cmd_push = 1'b0;
    endtask

    task automatic push_tx(input logic [31:0] w);
        @(negedge clk); tx_push = 1'b1; tx_word = w;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic read_rx(output logic [31:0] v);
        @(negedge clk);
        while (!rx_not_empty) @(negedge clk);
        v = rx_data; rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!cmd_empty) @(negedge clk);
        while (!cs_n) @(negedge clk);
        repeat (80) @(negedge clk);
    endtask

    // Command encodings (see requirements).
    localparam logic [19:0] C_ASSERT2 = 20'h05002;
    localparam logic [19:0] C_RELEASE = 20'h04003;
    localparam logic [19:0] C_IMM     = 20'h15400;
    localparam logic [19:0] C_RX1     = 20'h25501;

    // Vector fields: {cpol, cpha, div[2:0], byte[7:0]}.
    localparam logic [12:0] VEC [6] = '{
        {1'b0, 1'b0, 3'd0, 8'hA5},
        {1'b0, 1'b1, 3'd1, 8'h3C},
        {1'b1, 1'b0, 3'd2, 8'h81},
        {1'b1, 1'b1, 3'd0, 8'h7E},
        {1'b0, 1'b0, 3'd3, 8'hC3},
        {1'b1, 1'b1, 3'd1, 8'h01}
    };

    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1; bad = bad + 1;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int lowc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 and R11: reset state.
        chk("R1 cs_n", {31'd0, cs_n}, 32'd1);
        chk("R1 mosi", {31'd0, mosi}, 32'd1);
        chk("R1 sclk", {31'd0, sclk}, 32'd0);
        chk("R11 cmd_empty", {31'd0, cmd_empty}, 32'd1);
        chk("R11 tx_not_full", {31'd0, tx_not_full}, 32'd1);
        chk("R11 rx_not_empty", {31'd0, rx_not_empty}, 32'd0);

        // R2 enable gating, then R3 hold timing with cfg_div=1 (period 4).
        cfg_div = 3'd1;
        push_cmd(20'h05005);
        push_cmd(20'h04004);
        repeat (20) @(negedge clk);
        chk("R2 queue untouched", {31'd0, cmd_empty}, 32'd0);
        chk("R2 cs_n frozen", {31'd0, cs_n}, 32'd1);
        en = 1'b1;
        while (cs_n) @(negedge clk);
        lowc = 0;
        while (!cs_n) begin lowc = lowc + 1; @(negedge clk); end
        chk("R3 cs low cycles", lowc, 32'd21);
        wait_done();

        // Table walk: R4, R7, R8, R9 for each mode and divider.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            {cfg_cpol, cfg_cpha, cfg_div} = VEC[i][12:8];
            repeat (2) @(negedge clk);
            push_cmd(C_ASSERT2);
            push_cmd(C_IMM | {12'd0, VEC[i][7:0]});
            push_cmd(C_RX1);
            push_cmd(C_RELEASE);
            wait_done();
            chk("R4 byte count", scount, 32'd2);
            chk("R4 immediate byte", {24'd0, smem[0]}, {24'd0, VEC[i][7:0]});
            chk("R9 ones out on receive", {24'd0, smem[1]}, 32'h0000_00FF);
            chk("R8 edges per session", ecnt, 32'd32);
            chk("R7 byte edge span", t15 - t0, 32'd15 << VEC[i][10:8]);
            chk("R8 idle level", {31'd0, sclk}, {31'd0, VEC[i][12]});
            read_rx(v);
            chk("R9 loopback word", v, {24'd0, VEC[i][7:0]});
        end
        chk("R8 no edge with cs high", ebad, 32'd0);

        // R5 and R9: word packing across bursts, mode 0, fastest clock.
        @(negedge clk); cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_div = 3'd0;
        push_tx(32'h4433_2211);
        push_tx(32'hFFFF_6655);
        push_tx(32'h0000_00AA);
        push_cmd(C_ASSERT2);
        push_cmd(20'h15506);
        push_cmd(20'h15501);
        push_cmd(20'h25506);
        push_cmd(C_RELEASE);
        wait_done();
        chk("R5 byte count", scount, 32'd13);
        chk("R5 first byte lsb", {24'd0, smem[0]}, 32'h11);
        chk("R5 last byte of run", {24'd0, smem[5]}, 32'h66);
        chk("R5 padding skipped", {24'd0, smem[6]}, 32'hAA);
        chk("R11 rx_not_empty", {31'd0, rx_not_empty}, 32'd1);
        read_rx(v);
        chk("R9 full word", v, 32'hFFFF_FFAA);
        read_rx(v);
        chk("R9 partial word", v, 32'h0000_FFFF);

        // R6: power-of-two length, n=3 gives 8 bytes.
        push_tx(32'h0403_0201);
        push_tx(32'h0807_0605);
        push_cmd(C_ASSERT2);
        push_cmd(20'h15703);
        push_cmd(C_RELEASE);
        wait_done();
        chk("R6 byte count", scount, 32'd8);
        chk("R6 last byte", {24'd0, smem[7]}, 32'h08);

        // R10: burst waits for transmit data with SCLK idle.
        push_cmd(C_ASSERT2);
        push_cmd(20'h15502);
        repeat (100) @(negedge clk);
        chk("R10 no edges while starved", ecnt, 32'd0);
        chk("R10 sclk idle", {31'd0, sclk}, 32'd0);
        chk("R10 cs held", {31'd0, cs_n}, 32'd0);
        push_tx(32'h0000_BEEF);
        push_cmd(C_RELEASE);
        wait_done();
        chk("R10 bytes after stall", scount, 32'd2);
        chk("R10 stalled data", {16'd0, smem[1], smem[0]}, 32'h0000_BEEF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule